// File: doc/BRIEF.md
# Two-Format 16-bit Accumulator Processor Core

This block is a single-cycle 16-bit processor core with three architectural registers: an address/data register (A), a data register (D) and a program counter (PC). Each clock it fetches one word from an instruction ROM port, executes it and commits the results at the next rising edge. Word bit 15 picks one of two formats. The constant format copies the whole word into A. The compute format feeds D and either A or the data word read at address A into a six-control ALU. It sends the result to any combination of memory, D and A, and can branch to A when the result meets a sign or zero test.

The core also watches for the two endless-loop idioms that programs use to finish. The first is an unconditional jump with no destination that targets its own address. The second is the same jump placed right after a constant load of that load's own address. When either appears, the core raises `halted` and freezes until reset. The ROM contents, the data memory and any peripherals sit outside the block. The core expects both the ROM and the data memory to answer reads combinationally within the same cycle.

Top module: `accum_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, A, D and PC are cleared to zero and `halted` is cleared. `mem_we` stays low for as long as `rst_n` is low.
- R2: A word with bit 15 at 0 loads all 16 of its bits into A, advances PC by one and does not write memory.
- R3: In a compute word, bits [11:6] control the ALU, most significant first: zero x, invert x, zero y, invert y, add (1) or bitwise AND (0), invert output. Here x is D. Invert means bitwise NOT.
- R4: Compute-word bit 12 selects y. At 1, y is `mem_rdata`, the data read at address A. At 0, y is the A register.
- R5: Compute-word bit 3 writes the result to memory at the address A held before the word (`mem_we` high, `mem_wdata` = result). Bit 4 loads D and bit 5 loads A. With bit 3 clear, `mem_we` is low.
- R6: Jump field bits [2:0] test the result. Bit 0 tests signed greater than zero, bit 1 tests equal to zero and bit 2 tests negative. The jump is taken when any enabled test holds. A field of 0 never jumps.
- R7: A taken jump loads PC with A's value after this word's destination writes. Otherwise PC advances by one. `rom_addr` shows the low bits of PC.
- R8: A compute word with destination field 0 and jump field 7 halts the core when A equals PC. In that case no register changes and `halted` rises after that edge.
- R9: The same word also halts the core when A equals PC−1, the previous cycle's fetch came from address A, and that fetched word equals A. If the earlier word differs from A, the core jumps instead.
- R10: Once `halted` is high, it stays high and A, D and PC hold, with `mem_we` low, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rom_addr | output | ADDR_W | Instruction fetch address (low bits of PC) |
| rom_data | input | 16 | Instruction word at `rom_addr` |
| mem_addr | output | ADDR_W | Data memory address (low bits of A) |
| mem_wdata | output | 16 | Data memory write value (ALU result) |
| mem_we | output | 1 | Data memory write enable |
| mem_rdata | input | 16 | Data memory word at `mem_addr` |
| halted | output | 1 | Core has stopped on an endless-loop idiom |

## Verification
The assertions check several rules on every cycle: the post-reset state, the stickiness of the halt, the frozen PC and A and the absence of writes while halted, the constant load into A, the sequential PC after a compute word with an empty jump field, and the absence of a write when the memory destination bit is clear. The ALU function table, operand selection, the destination mix and the jump conditions under negative, zero and positive results can only be shown by the bench's sweeps. The same holds for telling each halt idiom apart from the near misses that must jump instead, because a reference model follows those sweeps cycle by cycle.

// File: rtl/accum_pkg.sv
// Package: shared word type, ALU control struct and the bit positions of the
// compute format. Assumes a fixed 16-bit instruction and data word.
package accum_pkg;

    localparam int WORD_W    = 16;
    localparam int FMT_BIT   = 15;
    localparam int YSEL_BIT  = 12;
    localparam int FN_LSB    = 6;
    localparam int DEST_LSB  = 3;
    localparam int COND_LSB  = 0;

    localparam int DEST_MEM  = 0;
    localparam int DEST_D    = 1;
    localparam int DEST_A    = 2;

    typedef logic [WORD_W-1:0] word_t;

    // ALU controls, most significant first as they sit in the word
    typedef struct packed {
        logic clr_x;
        logic inv_x;
        logic clr_y;
        logic inv_y;
        logic sum;
        logic inv_out;
    } alu_ctl_t;

endpackage

// File: rtl/accum_alu.sv
// Module: six-control ALU. Conditions each operand (clear, invert), adds or
// ANDs them, optionally inverts the output and reports zero/negative flags.
// Assumes: purely combinational, two's complement sign in the top bit.
module accum_alu
    import accum_pkg::*;
(
    input  word_t    x_in,
    input  word_t    y_in,
    input  alu_ctl_t ctl,
    output word_t    result,
    output logic     is_zero,
    output logic     is_neg
);

    word_t x_c, y_c, core;

    // Condition both operands, combine them, then condition the output
    always_comb begin
        x_c = ctl.clr_x ? '0 : x_in;
        x_c = ctl.inv_x ? ~x_c : x_c;
        y_c = ctl.clr_y ? '0 : y_in;
        y_c = ctl.inv_y ? ~y_c : y_c;
        core   = ctl.sum ? (x_c + y_c) : (x_c & y_c);
        result = ctl.inv_out ? ~core : core;
    end

    assign is_zero = (result == '0);
    assign is_neg  = result[WORD_W-1];

endmodule

// File: rtl/accum_branch.sv
// Module: jump decision. Each of the three jump-field bits enables one
// result test (greater than zero, zero, negative); any enabled match jumps.
// Assumes: enable is low for constant-format words.
module accum_branch
    import accum_pkg::*;
#(
    parameter int N_COND = 3
) (
    input  logic              enable,
    input  logic [N_COND-1:0] cond,
    input  logic              is_zero,
    input  logic              is_neg,
    output logic              take
);

    logic [N_COND-1:0] flag;
    logic [N_COND-1:0] hit;

    // Result tests in jump-field bit order: positive, zero, negative
    assign flag = {is_neg, is_zero, ~is_neg & ~is_zero};

    generate
        for (genvar i = 0; i < N_COND; i++) begin : g_cond
            assign hit[i] = cond[i] & flag[i];
        end
    endgenerate

    assign take = enable & (|hit);

endmodule

// File: rtl/accum_halt_det.sv
// Module: endless-loop detector. Flags an unconditional jump with no
// destination that targets its own address, or targets the previous address
// when the word fetched there in the previous cycle loads that same address.
// Assumes: ROM is read-only, so a one-entry record of the last fetch is enough.
module accum_halt_det
    import accum_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  advance,
    input  word_t pc,
    input  word_t a_val,
    input  word_t instr,
    output logic  hit
);

    word_t prev_pc;
    word_t prev_word;
    logic  prev_ok;
    logic  idiom;
    logic  self_loop;
    logic  loader_loop;

    // Remember the address and word of the last executed fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_pc   <= '0;
            prev_word <= '0;
            prev_ok   <= 1'b0;
        end else if (advance) begin
            prev_pc   <= pc;
            prev_word <= instr;
            prev_ok   <= 1'b1;
        end
    end

    // Recognise the two loop shapes
    always_comb begin
        idiom = instr[FMT_BIT]
              && (instr[DEST_LSB +: 3] == 3'b000)
              && (instr[COND_LSB +: 3] == 3'b111);
        self_loop   = (a_val == pc);
        loader_loop = (a_val == pc - 16'd1) && prev_ok
                   && (prev_pc == a_val) && (prev_word == a_val);
        hit = idiom && (self_loop || loader_loop);
    end

endmodule

// File: rtl/accum_core.sv
// Module: single-cycle two-format 16-bit core (top). Fetches from rom_data,
// executes, and commits A, D and PC at each rising edge until a loop idiom
// halts it. Assumes combinational ROM and data-memory reads.
module accum_core
    import accum_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [15:0]       rom_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              mem_we,
    input  logic [15:0]       mem_rdata,
    output logic              halted
);

    localparam int COND_W = 3;

    word_t    a_q, d_q, pc_q;
    logic     halt_q;
    logic     run;
    logic     is_comp;
    logic [2:0] dest;
    logic [COND_W-1:0] cond;
    alu_ctl_t ctl;
    word_t    y_sel, result, a_next, d_next, pc_next;
    logic     is_zero, is_neg, take, halt_hit;

    // Field extraction from the fetched word
    always_comb begin
        is_comp = rom_data[FMT_BIT];
        dest    = rom_data[DEST_LSB +: 3];
        cond    = rom_data[COND_LSB +: COND_W];
        ctl     = alu_ctl_t'(rom_data[FN_LSB +: 6]);
        y_sel   = rom_data[YSEL_BIT] ? mem_rdata : a_q;
    end

    assign run = !halt_q;

    accum_alu u_alu (
        .x_in    (d_q),
        .y_in    (y_sel),
        .ctl     (ctl),
        .result  (result),
        .is_zero (is_zero),
        .is_neg  (is_neg)
    );

    accum_branch #(.N_COND(COND_W)) u_branch (
        .enable  (is_comp),
        .cond    (cond),
        .is_zero (is_zero),
        .is_neg  (is_neg),
        .take    (take)
    );

    accum_halt_det u_halt (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (run),
        .pc      (pc_q),
        .a_val   (a_q),
        .instr   (rom_data),
        .hit     (halt_hit)
    );

    // Next-state values for A, D and PC
    always_comb begin
        if (is_comp) begin
            a_next = dest[DEST_A] ? result : a_q;
            d_next = dest[DEST_D] ? result : d_q;
        end else begin
            a_next = rom_data;
            d_next = d_q;
        end
        pc_next = take ? a_next : pc_q + 16'd1;
    end

    // Architectural register update and halt latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            d_q    <= '0;
            pc_q   <= '0;
            halt_q <= 1'b0;
        end else if (run) begin
            if (halt_hit) begin
                halt_q <= 1'b1;
            end else begin
                a_q  <= a_next;
                d_q  <= d_next;
                pc_q <= pc_next;
            end
        end
    end

    assign rom_addr  = pc_q[ADDR_W-1:0];
    assign mem_addr  = a_q[ADDR_W-1:0];
    assign mem_wdata = result;
    assign mem_we    = rst_n && run && is_comp && dest[DEST_MEM];
    assign halted    = halt_q;

endmodule

// File: rtl/accum_core_chk.sv
// Module: port-level checker for accum_core, attached by bind below.
// Assumes: synchronous active-low reset, halted registered.
module accum_core_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rom_addr,
    input logic [15:0]       rom_data,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              halted
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rom_addr == '0 && mem_addr == '0 && !halted));

    // R1
    reset_no_write_chk: assert property (@(posedge clk)
        !rst_n |-> !mem_we);

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R10
    halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R10
    halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(rom_addr) && $stable(mem_addr)));

    // R2
    const_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !rom_data[15]) |=>
            (mem_addr == $past(rom_data[ADDR_W-1:0])
             && rom_addr == $past(rom_addr) + 1'b1));

    // R6
    no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && rom_data[15] && rom_data[2:0] == 3'b000) |=>
            (rom_addr == $past(rom_addr) + 1'b1));

    // R5
    no_mem_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_data[15] && !rom_data[3]) |-> !mem_we);

endmodule

bind accum_core accum_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rom_addr (rom_addr),
    .rom_data (rom_data),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .halted   (halted)
);

// File: tb/accum_core_bench.sv
`timescale 1ns/1ps
// Bench: drives instruction words directly as the ROM, answers data reads
// with an address-derived pattern and follows the core with its own model.
module accum_core_bench;

    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] rom_addr;
    logic [15:0]   rom_data = 16'hFFF8;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic          mem_we;
    logic [15:0]   mem_rdata;
    logic          halted;

    int checks = 0;
    int failures = 0;

    // reference state
    logic [15:0] mA, mD, mPC, lAddr, lWord;
    logic        mHalt, lValid;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] pattern(input logic [AW-1:0] ad);
        return ({1'b0, ad} * 16'd40503) ^ 16'hC35A;
    endfunction

    assign mem_rdata = pattern(mem_addr);

    accum_core #(.ADDR_W(AW)) u_accum_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    function automatic logic [15:0] alu_ref(input logic [15:0] x, input logic [15:0] y,
                                            input logic [5:0] f);
        logic [15:0] xv, yv, o;
        xv = f[5] ? 16'd0 : x;
        if (f[4]) xv = 16'hFFFF - xv;
        yv = f[3] ? 16'd0 : y;
        if (f[2]) yv = 16'hFFFF - yv;
        o = f[1] ? xv + yv : xv & yv;
        if (f[0]) o = 16'hFFFF - o;
        return o;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Execute one word: compare ports with the model, then advance the model
    task automatic step(input logic [15:0] w);
        logic [15:0] y, res, nA, oldpc;
        logic        hit, jmp;
        rom_data = w;
        #1;
        chk(rom_addr == mPC[AW-1:0], "R7", {1'b0, rom_addr}, {1'b0, mPC[AW-1:0]});
        chk(mem_addr == mA[AW-1:0], "R2", {1'b0, mem_addr}, {1'b0, mA[AW-1:0]});
        chk(halted == mHalt, "R10", {15'd0, halted}, {15'd0, mHalt});
        y = w[12] ? pattern(mA[AW-1:0]) : mA;
        res = alu_ref(mD, y, w[11:6]);
        if (mHalt || !w[15]) begin
            chk(mem_we == 1'b0, mHalt ? "R10" : "R2", {15'd0, mem_we}, 16'd0);
        end else begin
            chk(mem_we == w[3], "R5", {15'd0, mem_we}, {15'd0, w[3]});
            if (w[3])
                chk(mem_wdata == res, w[12] ? "R4" : "R3", mem_wdata, res);
        end
        oldpc = mPC;
        if (!mHalt) begin
            if (w[15]) begin
                hit = (w[5:3] == 3'd0) && (w[2:0] == 3'd7) &&
                      (mA == mPC || (mA == mPC - 16'd1 && lValid && lAddr == mA && lWord == mA));
                if (hit) begin
                    mHalt = 1'b1;
                end else begin
                    nA = w[5] ? res : mA;
                    if (w[4]) mD = res;
                    jmp = (w[0] && !res[15] && res != 0) || (w[1] && res == 0) ||
                          (w[2] && res[15]);
                    mPC = jmp ? nA : mPC + 16'd1;
                    mA  = nA;
                end
            end else begin
                mA  = w;
                mPC = mPC + 16'd1;
            end
            lAddr = oldpc;
            lWord = w;
            lValid = 1'b1;
        end
        @(negedge clk);
    endtask

    function automatic logic [15:0] cw(input logic ysel, input logic [5:0] f,
                                       input logic [2:0] d, input logic [2:0] j);
        return {3'b111, ysel, f, d, j};
    endfunction

    task automatic set_d(input logic [15:0] v);
        if (!v[15]) begin
            step({1'b0, v[14:0]});
            step(cw(1'b0, 6'b110000, 3'b010, 3'b000));
        end else begin
            step({1'b0, ~v[14:0]});
            step(cw(1'b0, 6'b110001, 3'b010, 3'b000));
        end
    endtask

    task automatic set_a(input logic [15:0] v);
        if (!v[15]) begin
            step({1'b0, v[14:0]});
        end else begin
            step({1'b0, ~v[14:0]});
            step(cw(1'b0, 6'b110001, 3'b100, 3'b000));
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        rom_data = 16'hFFF8;
        repeat (2) @(negedge clk);
        #1;
        // R1: reset state and no write even with a memory destination fetched
        chk(rom_addr == '0, "R1", {1'b0, rom_addr}, 16'd0);
        chk(mem_addr == '0, "R1", {1'b0, mem_addr}, 16'd0);
        chk(halted == 1'b0, "R1", {15'd0, halted}, 16'd0);
        chk(mem_we == 1'b0, "R1", {15'd0, mem_we}, 16'd0);
        mA = 0; mD = 0; mPC = 0; mHalt = 0; lValid = 0; lAddr = 0; lWord = 0;
        rst_n = 1'b1;
    endtask

    localparam logic [15:0] LOOP_JMP = 16'hEA87;  // 0;JMP, no destination

    initial begin
        logic [15:0] dv, av;
        do_reset();

        // R3 R4: every ALU control code, both operand selects, several pairs
        for (int f = 0; f < 64; f++) begin
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < 5; k++) begin
                    case (k)
                        0: begin dv = 16'h0000; av = 16'h0000; end
                        1: begin dv = 16'h1234; av = 16'h0F0F; end
                        2: begin dv = 16'hFFFF; av = 16'h0001; end
                        3: begin dv = 16'h8000; av = 16'h7FFF; end
                        default: begin dv = 16'(f * 977) ^ 16'hBEEF; av = 16'(f * 313 + 7); end
                    endcase
                    set_d(dv);
                    set_a(av);
                    step(cw(s[0], 6'(f), 3'b001, 3'b000));
                end
            end
        end

        // R5: every destination mix, D read back through a memory write
        for (int d = 0; d < 8; d++) begin
            set_d(16'h0321 + 16'(d));
            set_a(16'h0100 + 16'(d * 3));
            step(cw(1'b0, 6'b000010, 3'(d), 3'b000));
            step(cw(1'b0, 6'b001100, 3'b001, 3'b000));
        end

        // R6 R7: every jump field against negative, zero and positive results
        for (int j = 0; j < 8; j++) begin
            for (int v = 0; v < 3; v++) begin
                dv = (v == 0) ? 16'h8001 : (v == 1) ? 16'h0000 : 16'h0005;
                set_d(dv);
                set_a((mPC + 16'd9) & 16'h7FFF);
                step(cw(1'b0, 6'b001100, 3'b000, 3'(j)));
                set_d(dv + 16'h0040);
                set_a((mPC + 16'd9) & 16'h7FFF);
                step(cw(1'b0, 6'b001100, 3'b100, 3'(j)));  // target is the new A
            end
        end

        // R9 near miss: A = PC-1 but the word there is not a self-load
        step({1'b0, 15'(mPC + 16'd1)});
        step(cw(1'b0, 6'b001100, 3'b010, 3'b000));
        step(LOOP_JMP);
        chk(halted == 1'b0, "R9", {15'd0, halted}, 16'd0);
        // R8 near miss: self-target jump that also writes D
        step({1'b0, 15'(mPC + 16'd1)});
        step(cw(1'b0, 6'b101010, 3'b010, 3'b111));
        chk(halted == 1'b0, "R8", {15'd0, halted}, 16'd0);
        // R8 near miss: conditional self-target jump
        step({1'b0, 15'(mPC + 16'd1)});
        step(cw(1'b0, 6'b101010, 3'b000, 3'b010));
        chk(halted == 1'b0, "R8", {15'd0, halted}, 16'd0);

        // R8: self loop halts, R10 freeze afterwards
        set_d(16'h0777);
        step({1'b0, 15'(mPC + 16'd1)});
        step(LOOP_JMP);
        chk(halted == 1'b1, "R8", {15'd0, halted}, 16'd1);
        step(cw(1'b0, 6'b001100, 3'b111, 3'b111));
        step({1'b0, 15'h1234});
        step(cw(1'b1, 6'b000010, 3'b011, 3'b000));
        chk(halted == 1'b1, "R10", {15'd0, halted}, 16'd1);

        // R9: loader loop halts
        do_reset();
        set_d(16'h0042);
        step({1'b0, 15'(mPC)});
        step(LOOP_JMP);
        chk(halted == 1'b1, "R9", {15'd0, halted}, 16'd1);
        step(cw(1'b0, 6'b001100, 3'b001, 3'b000));
        step(cw(1'b0, 6'b001100, 3'b001, 3'b000));

        do_reset();
        step({1'b0, 15'h0ABC});
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule